// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes, or 9-bit words, over a single NRZ serial line. A host writes a word into a one-entry holding register. Whenever no frame is in progress, the word moves into an internal shift register at the end of a divisor period, and the frame goes out as a low start bit, the data bits least significant first, an optional ninth bit and a high stop bit. Parity is not produced by the hardware. If the ninth bit is wanted, the host supplies it as a plain data value.

An 8-bit programmable divisor produces one tick every `baud_div + 1` system clocks. Each bit lasts 64 ticks. Because the holding register is refilled while the shift register is busy, consecutive frames can follow each other with no idle time. The host sees two status outputs. `hold_empty` reports the holding register and feeds the interrupt output. `shift_empty` reports the shift register and has no interrupt.

Dropping `tx_en` abandons the frame in progress, clears the shifter and the divisor, and releases the line through `ser_oe`.

Top module: `sertx_top`

## Requirements
- R1: A frame is a start bit of 0, then `wr_data[0]` through `wr_data[7]` in that order, then (9-bit mode only) the ninth bit, then a stop bit of 1. While enabled and not sending, `ser_out` is 1.
- R2: Every bit, the start bit included, lasts exactly 64*(`baud_div`+1) system clocks.
- R3: The holding word moves to the shift register only when `tx_en` is high, the shift register is free (or its stop bit ends on that tick), and a divisor tick occurs. With `tx_en` low a written word stays in the holding register.
- R4: `hold_empty` is 1 whenever the holding register is empty, whatever `irq_en` says. It goes to 0 in the cycle after a write and returns to 1 only after a transfer.
- R5: `irq` equals `hold_empty` AND `irq_en`.
- R6: `shift_empty` is 0 while a frame is on the line and 1 otherwise.
- R7: A word written while `tx_en` is low is sent once `tx_en` rises.
- R8: A word waiting in the holding register when a stop bit ends starts its start bit on the same clock, so there is no idle gap.
- R9: When `tx_en` goes low, `ser_oe` goes low in the same cycle and `shift_empty` is 1 after the next clock edge. After re-enabling, the line idles at 1.
- R10: `nine_mode` and `ninth_bit` are sampled at the transfer, not at the write. With `nine_mode` = 0 the frame has 10 bits, and with `nine_mode` = 1 it has 11.
- R11: After reset `hold_empty` = 1, `shift_empty` = 1, `irq` = 0 with `irq_en` = 0, and `ser_oe` follows `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 8 | Divisor; one tick per baud_div+1 clocks |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Word written by the host |
| ninth_bit | input | 1 | Value sent as the ninth data bit |
| nine_mode | input | 1 | 1 selects 9 data bits |
| tx_en | input | 1 | Transmit enable; low aborts and releases the line |
| irq_en | input | 1 | Interrupt enable |
| hold_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty status |
| ser_out | output | 1 | Serial data value |
| ser_oe | output | 1 | Output enable for the serial pin |

## Verification
The assertions assume that `baud_div` does not change while a frame is on the line, that `wr_en` is a one-cycle strobe, and that `nine_mode` and `ninth_bit` are settled before the transfer edge they should affect. The stimulus changes the divisor and the format only while the line is idle, except for one deliberate case. In that case `ninth_bit` is altered after a word has been written but before that word is transferred, which shows that the value is taken at the transfer. All inputs are driven on the falling clock edge, so each one is stable across every rising edge.

// File: rtl/sertx_pkg.sv
// Shared definitions for the serial transmitter.
// Assumes: oversampling factor is a power of two given as its log2.
package sertx_pkg;
    localparam int unsigned OVS_LOG2 = 6;   // 64 ticks per bit

    typedef enum logic {
        FMT_8BIT = 1'b0,
        FMT_9BIT = 1'b1
    } frame_fmt_e;
endpackage

// File: rtl/sertx_baud.sv
// Divisor tick generator: pulses tick for one clock every div+1 clocks.
// Assumes: div is stable while run is high; counter restarts when run drops.
module sertx_baud #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count up to the divisor value and wrap; held at zero when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt == div) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Tick marks the last clock of each divisor period.
    assign tick = run && (cnt == div);
endmodule

// File: rtl/sertx_hold.sv
// One-entry holding register between the host and the shift register.
// Assumes: a write and a take in the same cycle keep the new word
// (the take consumes the word present before the write).
module sertx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Track occupancy: writes fill, takes drain, writes win on a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)    full <= 1'b0;
        else if (wr)   full <= 1'b1;
        else if (take) full <= 1'b0;
    end

    // Capture the host word on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)  data <= '0;
        else if (wr) data <= wdata;
    end

    // R4: a write always leaves the register occupied.
    a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> full);
    // R4: the register empties only through a transfer.
    a_r4_clear_by_take: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |-> $past(take));
endmodule

// File: rtl/sertx_shifter.sv
// Frame shifter: loads start, data, optional ninth and stop bits from the
// holding register and shifts them out, one bit per 2**OVS_LOG2 ticks.
// Assumes: tick is a one-clock pulse; en low aborts and clears all state.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              nine_mode,
    input  logic              ninth,
    output logic              take,
    output logic              busy,
    output logic              line
);
    localparam int unsigned FRAME_W = DATA_W + 3;
    localparam int unsigned CNT_W   = $clog2(FRAME_W);

    logic [FRAME_W-1:0]  shreg;
    logic [FRAME_W-1:0]  frame_in;
    logic [CNT_W-1:0]    bit_cnt;
    logic [CNT_W-1:0]    last_idx;
    logic [OVS_LOG2-1:0] sub;
    frame_fmt_e          fmt;
    logic                bit_end;
    logic                frame_done;

    // Frame image: bit 0 start, then data LSB first, ninth (or filler 1), stop.
    assign frame_in   = {1'b1, (nine_mode ? ninth : 1'b1), buf_data, 1'b0};
    assign fmt        = nine_mode ? FMT_9BIT : FMT_8BIT;
    assign bit_end    = busy && tick && (sub == '1);
    assign frame_done = bit_end && (bit_cnt == last_idx);
    // Transfer on a tick when idle or exactly as the stop bit finishes.
    assign take       = en && tick && buf_full && (!busy || frame_done);

    // Frame sequencing: load, count ticks within a bit, shift, finish.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            busy     <= 1'b0;
            shreg    <= '1;
            bit_cnt  <= '0;
            sub      <= '0;
            last_idx <= '0;
        end else if (take) begin
            busy     <= 1'b1;
            shreg    <= frame_in;
            bit_cnt  <= '0;
            sub      <= '0;
            last_idx <= (fmt == FMT_9BIT) ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
        end else if (frame_done) begin
            busy     <= 1'b0;
            shreg    <= '1;
        end else if (busy && tick) begin
            sub <= sub + 1'b1;
            if (bit_end) begin
                shreg   <= {1'b1, shreg[FRAME_W-1:1]};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Line idles high; otherwise shows the current frame bit.
    assign line = busy ? shreg[0] : 1'b1;

    // R1: a transfer is followed by a start bit on the line.
    a_r1_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (line == 1'b0));
    // R9: dropping the enable clears the frame at the next edge.
    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
endmodule

// File: rtl/sertx_top.sv
// Double-buffered asynchronous serial transmitter top level.
// Assumes: baud_div held stable during a frame; wr_en is a single-cycle strobe.
module sertx_top #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ninth_bit,
    input  logic              nine_mode,
    input  logic              tx_en,
    input  logic              irq_en,
    output logic              hold_empty,
    output logic              irq,
    output logic              shift_empty,
    output logic              ser_out,
    output logic              ser_oe
);
    logic              tick;
    logic              take;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              busy;
    logic              line;

    sertx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .div(baud_div), .tick(tick)
    );

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(wr_data),
        .take(take), .full(buf_full), .data(buf_data)
    );

    sertx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tick),
        .buf_full(buf_full), .buf_data(buf_data),
        .nine_mode(nine_mode), .ninth(ninth_bit),
        .take(take), .busy(busy), .line(line)
    );

    // Status and pin outputs.
    assign hold_empty  = !buf_full;
    assign irq         = hold_empty && irq_en;
    assign shift_empty = !busy;
    assign ser_out     = line;
    assign ser_oe      = tx_en;

    // R3: a transfer without a simultaneous write leaves the buffer empty.
    a_r3_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> hold_empty);
endmodule

// File: tb/test_sertx_top.sv
module test_sertx_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] baud_div;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       ninth_bit;
    logic       nine_mode;
    logic       tx_en;
    logic       irq_en;
    logic       hold_empty;
    logic       irq;
    logic       shift_empty;
    logic       ser_out;
    logic       ser_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    sertx_top i_sertx_top (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .wr_en(wr_en),
        .wr_data(wr_data), .ninth_bit(ninth_bit), .nine_mode(nine_mode),
        .tx_en(tx_en), .irq_en(irq_en), .hold_empty(hold_empty), .irq(irq),
        .shift_empty(shift_empty), .ser_out(ser_out), .ser_oe(ser_oe)
    );

    // Vector fields: {div[17:10], nine_mode[9], ninth[8], data[7:0]}
    localparam int NVEC = 6;
    localparam logic [17:0] VEC [NVEC] = '{
        {8'd0, 1'b0, 1'b0, 8'hA5},
        {8'd1, 1'b0, 1'b0, 8'h01},
        {8'd3, 1'b1, 1'b1, 8'h80},
        {8'd0, 1'b1, 1'b0, 8'hFF},
        {8'd2, 1'b0, 1'b1, 8'h3C},
        {8'd1, 1'b1, 1'b1, 8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Waits for a start bit, then samples every bit at its middle.
    task automatic grab(input int div, input bit m9, output logic [7:0] d,
                        output logic n, output logic stp, output bit got);
        int b = 64 * (div + 1);
        int w = 0;
        got = 1'b0; d = '0; n = 1'b0; stp = 1'b0;
        while (ser_out !== 1'b0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        if (ser_out !== 1'b0) return;
        got = 1'b1;
        repeat (b / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (b) @(negedge clk);
            d[i] = ser_out;
        end
        if (m9) begin
            repeat (b) @(negedge clk);
            n = ser_out;
        end
        repeat (b) @(negedge clk);
        stp = ser_out;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<190000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        logic [7:0] d;
        logic       n;
        logic       stp;
        bit         got;
        int         lowcnt;

        rst_n = 1'b0; baud_div = 8'd0; wr_en = 1'b0; wr_data = 8'h00;
        ninth_bit = 1'b0; nine_mode = 1'b0; tx_en = 1'b0; irq_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11 hold_empty", hold_empty, 1);
        chk("R11 shift_empty", shift_empty, 1);
        chk("R11 irq", irq, 0);
        chk("R11 ser_oe", ser_oe, 0);
        // R4/R5: flag is set regardless of enable; irq follows enable
        irq_en = 1'b1;
        @(negedge clk);
        chk("R5 irq with enable", irq, 1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R4 flag without enable", hold_empty, 1);
        chk("R5 irq masked", irq, 0);

        // R7 / R3: write while disabled, then enable
        irq_en = 1'b1;
        baud_div = 8'd1;
        host_write(8'h5A);
        chk("R4 flag clears on write", hold_empty, 0);
        chk("R5 irq drops on write", irq, 0);
        repeat (500) @(negedge clk);
        chk("R3 no transfer while disabled", hold_empty, 0);
        chk("R9 line released while disabled", ser_oe, 0);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R1 idle high when enabled", ser_out, 1);
        grab(1, 1'b0, d, n, stp, got);
        chk("R7 frame after enable", got, 1);
        chk("R7 data", d, 8'h5A);
        chk("R1 stop bit", stp, 1);
        chk("R4 flag set after transfer", hold_empty, 1);
        repeat (100) @(negedge clk);

        // Table walk: R1, R2, R10 across divisors and formats
        for (int v = 0; v < NVEC; v++) begin
            int dv;
            dv = int'(VEC[v][17:10]);
            @(negedge clk);
            baud_div  = VEC[v][17:10];
            nine_mode = VEC[v][9];
            ninth_bit = VEC[v][8];
            host_write(VEC[v][7:0]);
            chk("R4 flag low after write", hold_empty, 0);
            grab(dv, VEC[v][9], d, n, stp, got);
            chk("R1 frame seen", got, 1);
            chk("R1 data LSB first", d, VEC[v][7:0]);
            chk("R10 ninth bit", n, VEC[v][9] ? VEC[v][8] : 1'b0);
            chk("R1 stop bit", stp, 1);
            repeat (64 * (dv + 1)) @(negedge clk);
            chk("R6 idle after frame", shift_empty, 1);
            chk("R1 idle line high", ser_out, 1);
        end

        // R2: start bit length with divisor 2
        baud_div = 8'd2; nine_mode = 1'b0;
        host_write(8'hFF);
        while (ser_out !== 1'b0) @(negedge clk);
        chk("R6 busy during frame", shift_empty, 0);
        lowcnt = 0;
        while (ser_out === 1'b0 && lowcnt < 1000) begin
            @(negedge clk);
            lowcnt++;
        end
        chk("R2 start bit length", lowcnt, 192);
        repeat (192 * 10) @(negedge clk);

        // R8 / R10: back-to-back frames, ninth bit sampled at transfer
        baud_div = 8'd0; nine_mode = 1'b1; ninth_bit = 1'b1;
        host_write(8'h33);
        while (ser_out !== 1'b0) @(negedge clk);
        chk("R3 pass-through empties buffer", hold_empty, 1);
        host_write(8'hC4);
        chk("R8 second word held", hold_empty, 0);
        ninth_bit = 1'b0;
        grab(0, 1'b1, d, n, stp, got);
        chk("R8 first data", d, 8'h33);
        chk("R10 first ninth", n, 1);
        repeat (32) @(negedge clk);
        chk("R8 no idle gap", ser_out, 0);
        grab(0, 1'b1, d, n, stp, got);
        chk("R8 second data", d, 8'hC4);
        chk("R10 ninth taken at transfer", n, 0);
        chk("R1 second stop", stp, 1);
        repeat (64) @(negedge clk);

        // R9: abort mid-frame
        baud_div = 8'd1; nine_mode = 1'b0;
        host_write(8'h0F);
        while (ser_out !== 1'b0) @(negedge clk);
        repeat (300) @(negedge clk);
        chk("R6 busy before abort", shift_empty, 0);
        tx_en = 1'b0;
        #1;
        chk("R9 oe drops at once", ser_oe, 0);
        @(negedge clk);
        chk("R9 shifter cleared", shift_empty, 1);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R9 idle after re-enable", ser_out, 1);
        chk("R9 oe back", ser_oe, 1);
        repeat (400) @(negedge clk);
        chk("R9 no resumed frame", ser_out, 1);

        finish_run();
    end
endmodule